// File: doc/BRIEF.md
# Channel Status Word Bank with Interrupt Summary

This block holds one 32-bit control/status word for each of a set of transfer channels, together with the logic that reduces the interrupt-worthy bits of all the words into a per-channel summary vector and a single level interrupt. Software writes and reads the words through a simple 32-bit register port. The port addresses channel words at indices `0` to `NUM_CH-1`. The summary vector is at index `NUM_CH`.

A channel engine outside this block reports events as one-cycle pulses. The events are transfer start, transfer end, stop, end-of-receive and peripheral-request-asserted. Each engine also supplies a level showing that its peripheral request is active.

A single stored word mixes three kinds of bits:
- sticky event flags, cleared by writing one;
- enable and mode bits, replaced on every write;
- write-only command bits, which act once and are not stored.

Each channel has a small launch sequencer with four states: `LNCH_IDLE`, `LNCH_FETCH`, `LNCH_GO` and `LNCH_ACTIVE`. A write with the run bit set takes the sequencer from any state to `LNCH_FETCH`, or straight to `LNCH_GO` when the no-descriptor-fetch bit is set. The other transitions are:
- `LNCH_FETCH` goes to `LNCH_GO` on the next cycle.
- `LNCH_GO` goes to `LNCH_ACTIVE` on the next cycle.
- `LNCH_ACTIVE` goes to `LNCH_IDLE` once the stored stop bit is set.

In `LNCH_FETCH` the block drives a one-cycle descriptor fetch strobe. In `LNCH_GO` it drives a one-cycle start strobe.

Top module: `dcs_status_bank`

## Requirements
- R1: After reset every channel word reads 0x00000008 (only bit 3, stop, set), the summary register reads 0 and `irq` is low.
- R2: On a channel write, of the previous word only bits 0-4 and 8-10 survive. Of those, bits 0 (bus error), 1 (start), 2 (end) and 9 (end-of-receive) are cleared where the written value holds a 1. Bits 3, 4, 8 and 10 are not altered by writing one to them.
- R3: Bits 23 and 26-31 are replaced by the written value. Bits 5-7, 11-22, 24 and 25 are never stored and read as 0. Bit 22 is mask-run, bit 23 is request-asserted irq enable, bit 28 is end-of-receive irq enable, bit 29 is stop irq enable, bit 30 is no-descriptor-fetch and bit 31 is run.
- R4: A write with bit 31 set clears the stop bit and launches the channel. With bit 30 clear, `fetch_req` is high for the cycle after the write and `start_req` for the cycle after that. With bit 30 set, only `start_req` pulses, in the cycle after the write.
- R5: A write with both bit 31 and bit 22 clear sets the stop bit. A write with only bit 22 set leaves the stop bit as it was.
- R6: Writing 1 to bit 24 clears compare status (bit 10). Writing 1 to bit 25 sets it. When both are written, the bit ends set.
- R7: A channel read returns bit 8 as 1 whenever that channel's `req_active` input is high, independent of the stored bit.
- R8: Event pulses set their bits: start sets bit 1, end sets bit 2, stop sets bit 3, request-asserted sets bit 4 and end-of-receive sets bit 9. An event in the same cycle as a write is applied after the write, so it is never lost.
- R9: A channel's summary bit is set by any of the following: stop with stop irq enable, end-of-receive with its enable, request-asserted with its enable, start, or end. Start and end need no enable.
- R10: Reading index `NUM_CH` returns the summary vector with channel i in bit i. `irq` is high exactly when that vector is nonzero. Writes to that index change nothing.
- R11: Reads of indices above `NUM_CH` return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word index: channels, then summary |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_start | input | NUM_CH | Transfer start event per channel |
| evt_end | input | NUM_CH | Transfer end event per channel |
| evt_stop | input | NUM_CH | Channel stopped event |
| evt_eor | input | NUM_CH | End-of-receive event |
| evt_ras | input | NUM_CH | Peripheral request asserted event |
| req_active | input | NUM_CH | Peripheral request level per channel |
| fetch_req | output | NUM_CH | One-cycle descriptor fetch strobe |
| start_req | output | NUM_CH | One-cycle channel start strobe |
| run_level | output | NUM_CH | Stored run bit per channel |
| irq | output | 1 | Level interrupt, any summary bit set |

## Verification
The bench builds the block with `NUM_CH = 4`, which gives a three-bit index. With that width the summary sits at index 4, and indices 5 to 7 become reachable as unmapped reads. Four channels are enough to give each summary contributor its own channel. The summary can then be read as a distinct bit pattern that shows which gating held, including the set/clear interactions of the write-one-to-clear bits.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    // Bit positions inside a channel status word
    localparam int B_BUSERR    = 0;
    localparam int B_START     = 1;
    localparam int B_END       = 2;
    localparam int B_STOP      = 3;
    localparam int B_RAS       = 4;
    localparam int B_REQP      = 8;
    localparam int B_EOR       = 9;
    localparam int B_CMP       = 10;
    localparam int B_MASKRUN   = 22;
    localparam int B_RASEN     = 23;
    localparam int B_CMPCLR    = 24;
    localparam int B_CMPSET    = 25;
    localparam int B_EOREN     = 28;
    localparam int B_STOPEN    = 29;
    localparam int B_NODESC    = 30;
    localparam int B_RUN       = 31;

    localparam int WORD_W = 32;

    // Write composition masks
    localparam logic [WORD_W-1:0] KEEP_MASK  = 32'h0000_071F;
    localparam logic [WORD_W-1:0] W1C_MASK   = 32'h0000_0207;
    localparam logic [WORD_W-1:0] TAKE_MASK  = 32'hFC80_0000;
    localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_0008;

    typedef enum logic [1:0] {
        LNCH_IDLE,
        LNCH_FETCH,
        LNCH_GO,
        LNCH_ACTIVE
    } launch_e;

    typedef struct packed {
        logic start;
        logic fin;
        logic stop;
        logic eor;
        logic ras;
    } chan_evt_t;

    typedef struct packed {
        logic start;
        logic fin;
        logic stop;
        logic stop_en;
        logic eor;
        logic eor_en;
        logic ras;
        logic ras_en;
    } irq_src_t;

endpackage

// File: rtl/dcs_launch_fsm.sv
module dcs_launch_fsm
    import dcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic skip_fetch,
    input  logic stopped,
    output logic fetch_req,
    output logic start_req
);

    launch_e state_q;
    launch_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LNCH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a run write restarts the sequence from any state
    always_comb begin
        state_d = state_q;
        if (launch) begin
            state_d = skip_fetch ? LNCH_GO : LNCH_FETCH;
        end else begin
            unique case (state_q)
                LNCH_IDLE:   state_d = LNCH_IDLE;
                LNCH_FETCH:  state_d = LNCH_GO;
                LNCH_GO:     state_d = LNCH_ACTIVE;
                LNCH_ACTIVE: state_d = stopped ? LNCH_IDLE : LNCH_ACTIVE;
                default:     state_d = LNCH_IDLE;
            endcase
        end
    end

    // Strobes decoded from the state register only
    always_comb begin
        fetch_req = 1'b0;
        start_req = 1'b0;
        unique case (state_q)
            LNCH_FETCH: fetch_req = 1'b1;
            LNCH_GO:    start_req = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dcs_chan_word.sv
module dcs_chan_word
    import dcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wdata,
    input  chan_evt_t         evt,
    output logic [WORD_W-1:0] word_q,
    output irq_src_t          src,
    output logic              fetch_req,
    output logic              start_req
);

    logic [WORD_W-1:0] word_d;
    logic              launch;

    always_comb begin
        word_d = word_q;
        if (wr_sel) begin
            word_d = (word_q & KEEP_MASK & ~(wdata & W1C_MASK))
                   | (wdata & TAKE_MASK);
            if (wdata[B_RUN]) begin
                word_d[B_STOP] = 1'b0;
            end
            if (!wdata[B_RUN] && !wdata[B_MASKRUN]) begin
                word_d[B_STOP] = 1'b1;
            end
            if (wdata[B_CMPCLR]) begin
                word_d[B_CMP] = 1'b0;
            end
            if (wdata[B_CMPSET]) begin
                word_d[B_CMP] = 1'b1;
            end
        end
        // Engine events land after the write so none is lost
        if (evt.start) word_d[B_START] = 1'b1;
        if (evt.fin)   word_d[B_END]   = 1'b1;
        if (evt.stop)  word_d[B_STOP]  = 1'b1;
        if (evt.ras)   word_d[B_RAS]   = 1'b1;
        if (evt.eor)   word_d[B_EOR]   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= RESET_WORD;
        end else begin
            word_q <= word_d;
        end
    end

    always_comb begin
        src.start   = word_q[B_START];
        src.fin     = word_q[B_END];
        src.stop    = word_q[B_STOP];
        src.stop_en = word_q[B_STOPEN];
        src.eor     = word_q[B_EOR];
        src.eor_en  = word_q[B_EOREN];
        src.ras     = word_q[B_RAS];
        src.ras_en  = word_q[B_RASEN];
    end

    assign launch = wr_sel && wdata[B_RUN];

    dcs_launch_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .skip_fetch (wdata[B_NODESC]),
        .stopped    (word_q[B_STOP]),
        .fetch_req  (fetch_req),
        .start_req  (start_req)
    );

endmodule

// File: rtl/dcs_irq_merge.sv
module dcs_irq_merge
    import dcs_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  irq_src_t [NUM_CH-1:0] src,
    output logic     [NUM_CH-1:0] sum_vec,
    output logic                  irq
);

    logic [NUM_CH-1:0] stop_v;
    logic [NUM_CH-1:0] eor_v;
    logic [NUM_CH-1:0] ras_v;
    logic [NUM_CH-1:0] start_v;
    logic [NUM_CH-1:0] end_v;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_vec
        assign stop_v[c]  = src[c].stop && src[c].stop_en;
        assign eor_v[c]   = src[c].eor  && src[c].eor_en;
        assign ras_v[c]   = src[c].ras  && src[c].ras_en;
        assign start_v[c] = src[c].start;
        assign end_v[c]   = src[c].fin;
    end

    assign sum_vec = stop_v | eor_v | ras_v | start_v | end_v;
    assign irq     = |sum_vec;

endmodule

// File: rtl/dcs_status_bank.sv
module dcs_status_bank
    import dcs_pkg::*;
#(
    parameter  int NUM_CH = 8,
    localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] evt_start,
    input  logic [NUM_CH-1:0] evt_end,
    input  logic [NUM_CH-1:0] evt_stop,
    input  logic [NUM_CH-1:0] evt_eor,
    input  logic [NUM_CH-1:0] evt_ras,
    input  logic [NUM_CH-1:0] req_active,
    output logic [NUM_CH-1:0] fetch_req,
    output logic [NUM_CH-1:0] start_req,
    output logic [NUM_CH-1:0] run_level,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] SUM_ADDR = ADDR_W'(NUM_CH);

    logic     [NUM_CH-1:0][WORD_W-1:0] word_bus;
    irq_src_t [NUM_CH-1:0]             src_bus;
    logic     [NUM_CH-1:0]             sum_vec;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        chan_evt_t evt;
        logic      sel;

        assign evt.start = evt_start[c];
        assign evt.fin   = evt_end[c];
        assign evt.stop  = evt_stop[c];
        assign evt.eor   = evt_eor[c];
        assign evt.ras   = evt_ras[c];
        assign sel       = reg_wr && (reg_addr == ADDR_W'(c));

        dcs_chan_word u_word (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (sel),
            .wdata     (reg_wdata),
            .evt       (evt),
            .word_q    (word_bus[c]),
            .src       (src_bus[c]),
            .fetch_req (fetch_req[c]),
            .start_req (start_req[c])
        );

        assign run_level[c] = word_bus[c][B_RUN];
    end

    dcs_irq_merge #(.NUM_CH(NUM_CH)) u_merge (
        .src     (src_bus),
        .sum_vec (sum_vec),
        .irq     (irq)
    );

    // Read mux: channel words, summary, otherwise zero
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ADDR_W'(c)) begin
                reg_rdata = word_bus[c];
                if (req_active[c]) begin
                    reg_rdata[B_REQP] = 1'b1;
                end
            end
        end
        if (reg_addr == SUM_ADDR) begin
            reg_rdata[NUM_CH-1:0] = sum_vec;
        end
    end

endmodule

// File: rtl/dcs_status_chk.sv
module dcs_status_chk #(
    parameter  int NUM_CH = 8,
    localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         reg_wr,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [31:0]                  reg_wdata,
    input logic [31:0]                  reg_rdata,
    input logic [NUM_CH-1:0]            evt_stop,
    input logic [NUM_CH-1:0]            req_active,
    input logic [NUM_CH-1:0]            fetch_req,
    input logic [NUM_CH-1:0]            start_req,
    input logic [NUM_CH-1:0][31:0]      word_bus,
    input logic                         irq
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // R4
        fetch_then_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_req[g] && !(reg_wr && reg_addr == ADDR_W'(g) && reg_wdata[31])
            |=> start_req[g]);

        // R4
        strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(fetch_req[g] && start_req[g]));

        // R4
        run_clears_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            reg_wr && reg_addr == ADDR_W'(g) && reg_wdata[31] && !evt_stop[g]
            |=> !word_bus[g][3]);

        // R5
        plain_write_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
            reg_wr && reg_addr == ADDR_W'(g) && !reg_wdata[31] && !reg_wdata[22]
            |=> word_bus[g][3]);

        // R7
        req_pending_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            reg_addr == ADDR_W'(g) && req_active[g] |-> reg_rdata[8]);
    end

    // R10
    summary_matches_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == ADDR_W'(NUM_CH) |-> (irq == (reg_rdata != 32'h0)));

    // R3
    unstored_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr < ADDR_W'(NUM_CH) |-> (reg_rdata[25:24] == 2'b00 && !reg_rdata[22]));

endmodule

bind dcs_status_bank dcs_status_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .evt_stop   (evt_stop),
    .req_active (req_active),
    .fetch_req  (fetch_req),
    .start_req  (start_req),
    .word_bus   (word_bus),
    .irq        (irq)
);

// File: tb/dcs_status_bank_tb_top.sv
module dcs_status_bank_tb_top;

    localparam int NCH = 4;
    localparam int AW  = $clog2(NCH + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [AW-1:0]  reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] evt_start = '0;
    logic [NCH-1:0] evt_end = '0;
    logic [NCH-1:0] evt_stop = '0;
    logic [NCH-1:0] evt_eor = '0;
    logic [NCH-1:0] evt_ras = '0;
    logic [NCH-1:0] req_active = '0;
    logic [NCH-1:0] fetch_req;
    logic [NCH-1:0] start_req;
    logic [NCH-1:0] run_level;
    logic           irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dcs_status_bank #(.NUM_CH(NCH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .evt_start  (evt_start),
        .evt_end    (evt_end),
        .evt_stop   (evt_stop),
        .evt_eor    (evt_eor),
        .evt_ras    (evt_ras),
        .req_active (req_active),
        .fetch_req  (fetch_req),
        .start_req  (start_req),
        .run_level  (run_level),
        .irq        (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = AW'(idx);
        reg_wdata = data;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] data);
        reg_addr = AW'(idx);
        #1;
        data = reg_rdata;
    endtask

    task automatic rd_check(input string req, input int idx, input logic [31:0] exp);
        logic [31:0] v;
        rd(idx, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        for (int c = 0; c < NCH; c++) rd_check("R1 word", c, 32'h8);
        rd_check("R1 summary", NCH, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_launch();
        wr(0, 32'h8000_0000);
        check("R4 fetch strobe", {28'h0, fetch_req}, 32'h1);
        check("R4 no early start", {28'h0, start_req}, 32'h0);
        @(negedge clk);
        check("R4 start after fetch", {28'h0, start_req}, 32'h1);
        check("R4 fetch done", {28'h0, fetch_req}, 32'h0);
        @(negedge clk);
        check("R4 strobes idle", {24'h0, fetch_req, start_req}, 32'h0);
        rd_check("R4 R3 run word", 0, 32'h8000_0000);
        check("R3 run level", {28'h0, run_level}, 32'h1);
        wr(1, 32'hC000_0000);
        check("R4 nodesc start", {28'h0, start_req}, 32'h2);
        check("R4 nodesc no fetch", {28'h0, fetch_req}, 32'h0);
    endtask

    task automatic t_stop_write();
        wr(1, 32'h0000_0000);
        rd_check("R5 plain write stops", 1, 32'h8);
        wr(2, 32'h8000_0000);
        wr(2, 32'h0040_0000);
        rd_check("R5 R3 maskrun keeps stop clear", 2, 32'h0);
    endtask

    task automatic t_compare();
        wr(3, 32'h0200_0000);
        rd_check("R6 set compare", 3, 32'h408);
        wr(3, 32'h0100_0000);
        rd_check("R6 clear compare", 3, 32'h8);
        wr(3, 32'h0300_0000);
        rd_check("R6 both set wins", 3, 32'h408);
    endtask

    task automatic t_events_w1c();
        @(negedge clk);
        evt_start[3] = 1'b1; evt_end[3] = 1'b1; evt_eor[3] = 1'b1; evt_ras[3] = 1'b1;
        @(negedge clk);
        evt_start = '0; evt_end = '0; evt_eor = '0; evt_ras = '0;
        rd_check("R8 event bits", 3, 32'h61E);
        wr(3, 32'h0440_021F);
        rd_check("R2 w1c and sticky", 3, 32'h0400_0418);
    endtask

    task automatic t_req_pending();
        req_active[2] = 1'b1;
        rd_check("R7 pending forced", 2, 32'h100);
        req_active[2] = 1'b0;
        rd_check("R7 pending released", 2, 32'h0);
    endtask

    task automatic t_summary();
        do_reset();
        rd_check("R9 ungated stop", NCH, 32'h0);
        wr(0, 32'h2040_0000);
        rd_check("R9 stop enabled", NCH, 32'h1);
        check("R10 irq high", {31'h0, irq}, 32'h1);
        wr(NCH, 32'hFFFF_FFFF);
        rd_check("R10 summary write ignored", NCH, 32'h1);
        rd_check("R10 word untouched", 1, 32'h8);
        @(negedge clk); evt_ras[1] = 1'b1; @(negedge clk); evt_ras = '0;
        rd_check("R9 ras without enable", NCH, 32'h1);
        wr(1, 32'h00C0_0000);
        rd_check("R9 ras enabled", NCH, 32'h3);
        @(negedge clk); evt_start[2] = 1'b1; @(negedge clk); evt_start = '0;
        rd_check("R9 start unconditional", NCH, 32'h7);
        @(negedge clk); evt_eor[3] = 1'b1; @(negedge clk); evt_eor = '0;
        rd_check("R9 eor without enable", NCH, 32'h7);
        wr(3, 32'h1040_0000);
        rd_check("R9 eor enabled", NCH, 32'hF);
        wr(2, 32'h0040_0002);
        rd_check("R9 R2 start cleared", NCH, 32'hB);
        @(negedge clk); evt_end[2] = 1'b1; @(negedge clk); evt_end = '0;
        rd_check("R9 end unconditional", NCH, 32'hF);
    endtask

    task automatic t_event_vs_write();
        do_reset();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(0); reg_wdata = 32'h8000_0000;
        evt_stop[0] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_stop = '0;
        rd_check("R8 event beats write", 0, 32'h8000_0008);
        for (int a = NCH + 1; a < (1 << AW); a++) rd_check("R11 unmapped", a, 32'h0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_launch();
        t_stop_write();
        t_compare();
        t_events_w1c();
        t_req_pending();
        t_summary();
        t_event_vs_write();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule